// File: doc/BRIEF.md
# Compacting Alarm Detection List

This block records which alarms are currently active and in what order they came on. It holds up to eight alarm identifiers (11-bit numbers, 0 to 2047) in an ordered list, together with a binary count of the entries held. A set request appends an identifier behind the existing entries. A reset request names an identifier; if it is in the list, it is taken out and every later entry closes up by one slot toward the front. An indicator-reset request drops the oldest entry, so the list moves forward by one.

All eight slots, the count and a copy of the front slot are driven straight from registers. A supervisory controller can read the active alarms in activation order without scanning a flag array. The block is one of several small blocks in a larger chip. It keeps only the list and does not store the alarm flags themselves.

An occupancy state machine tracks whether the list is empty, partly filled or full. It has three states: ST_EMPTY, ST_PART and ST_FULL. The transitions are as follows:
- ADD takes ST_EMPTY to ST_PART.
- ADD with seven entries held takes ST_PART to ST_FULL.
- DEL or POP with one entry held takes ST_PART to ST_EMPTY.
- DEL or POP takes ST_FULL to ST_PART.
- Every other accepted operation stays in its state.
- A clear returns the machine to ST_EMPTY from any state.

Each cycle, a command arbiter picks one operation from the requests. The operations are OP_NONE, OP_ADD, OP_DEL and OP_POP.

Top module: `alarm_list`

## Requirements
- R1: While `clr` is high at a rising edge, the list is emptied: after that edge `count_o` is 0 and every slot reads 0.
- R2: An accepted set writes `set_id` into slot number `count_o` and raises `count_o` by one at the next edge, so slots keep activation order. Slot k is `slots_o[k*11 +: 11]`, with slot 0 at the least significant end.
- R3: A set whose identifier is already held in an occupied slot is ignored: slots and count stay unchanged.
- R4: `count_o` never exceeds 8. A set arriving while eight entries are held leaves slots and count unchanged.
- R5: A reset whose `rst_id` is held in slot k removes it. Every entry after k moves one slot toward the front, the last occupied slot becomes 0, and `count_o` drops by one.
- R6: A reset whose identifier is not in an occupied slot is ignored: slots and count stay unchanged.
- R7: An indicator-reset with at least one entry held discards slot 0, moves every other entry one slot forward and drops `count_o` by one.
- R8: An indicator-reset on an empty list has no effect.
- R9: Only one request acts per cycle, chosen in a fixed priority. Indicator-reset comes first, then reset, then set. The highest request that is asserted is the only one considered, even if it then has no effect.
- R10: Slots at positions equal to or above `count_o` always read 0, and `count_o` is a plain unsigned binary number.
- R11: `first_o` equals slot 0 in every cycle and changes at the same edge as the list.
- R12: Identifier 0 is an ordinary identifier. It matches only occupied slots, never the zero filling of empty slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr | input | 1 | Synchronous active-high clear |
| set_req | input | 1 | Request to append `set_id` |
| set_id | input | 11 | Identifier to append |
| rst_req | input | 1 | Request to remove `rst_id` by value |
| rst_id | input | 11 | Identifier to remove |
| ind_rst_req | input | 1 | Request to discard the oldest entry |
| slots_o | output | 88 | All eight slots, slot k in bits k*11 +: 11 |
| count_o | output | 4 | Number of entries held, binary |
| first_o | output | 11 | Copy of slot 0 |

## Verification
Any two or all three requests can fall in the same cycle. The most telling clash is an indicator-reset arriving together with a reset or a set, because the lower request must then leave no trace. The bench provokes these clashes in both a directed sequence and a long pseudo-random sweep over a small identifier pool, with each request raised independently. The expected list comes from a bench model that serves only the highest request. It is compared slot by slot after each edge, including cases where the winning request does nothing, such as an indicator-reset on an empty list that hides a valid set.

// File: rtl/alarm_list_pkg.sv
package alarm_list_pkg;

    // Operation chosen for the current cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_DEL  = 2'd2,
        OP_POP  = 2'd3
    } op_e;

    // Occupancy of the list
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_e;

endpackage

// File: rtl/alarm_match.sv
// Compares one key with every slot; only occupied slots can hit.
module alarm_match #(
    parameter int ID_W  = 11,
    parameter int DEPTH = 8
) (
    input  logic [DEPTH*ID_W-1:0] slots,
    input  logic [DEPTH-1:0]      valid,
    input  logic [ID_W-1:0]       key,
    output logic [DEPTH-1:0]      hit
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = valid[i] && (slots[i*ID_W +: ID_W] == key);
    end

endmodule

// File: rtl/alarm_cmd_arb.sv
// Chooses at most one operation per cycle: pop, then delete, then add.
module alarm_cmd_arb
    import alarm_list_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             ind_rst_req,
    input  logic             rst_req,
    input  logic             set_req,
    input  logic             is_empty,
    input  logic             is_full,
    input  logic [DEPTH-1:0] rst_hit,
    input  logic [DEPTH-1:0] set_hit,
    output op_e              op,
    output logic [IDX_W-1:0] del_pos
);

    logic             rst_found;
    logic             set_dup;
    logic [IDX_W-1:0] rst_pos;

    always_comb begin
        rst_found = |rst_hit;
        set_dup   = |set_hit;
        rst_pos   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (rst_hit[i]) begin
                rst_pos = IDX_W'(i);
            end
        end
    end

    always_comb begin
        op      = OP_NONE;
        del_pos = '0;
        if (ind_rst_req) begin
            if (!is_empty) begin
                op = OP_POP;
            end
        end else if (rst_req) begin
            if (rst_found) begin
                op      = OP_DEL;
                del_pos = rst_pos;
            end
        end else if (set_req) begin
            if (!is_full && !set_dup) begin
                op = OP_ADD;
            end
        end
    end

endmodule

// File: rtl/alarm_slot_lane.sv
// Next-value selection for one slot of the list.
module alarm_slot_lane
    import alarm_list_pkg::*;
#(
    parameter int ID_W  = 11,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4,
    parameter int INDEX = 0
) (
    input  op_e              op,
    input  logic [IDX_W-1:0] del_pos,
    input  logic [CNT_W-1:0] count,
    input  logic [ID_W-1:0]  new_id,
    input  logic [ID_W-1:0]  cur,
    input  logic [ID_W-1:0]  nxt,
    output logic [ID_W-1:0]  next_val
);

    localparam logic [CNT_W-1:0] MY_POS = CNT_W'(INDEX);

    logic at_tail;
    logic behind_gap;

    always_comb begin
        at_tail    = (count == MY_POS);
        behind_gap = (MY_POS >= CNT_W'(del_pos));
    end

    always_comb begin
        unique case (op)
            OP_ADD:  next_val = at_tail ? new_id : cur;
            OP_DEL:  next_val = behind_gap ? nxt : cur;
            OP_POP:  next_val = nxt;
            default: next_val = cur;
        endcase
    end

endmodule

// File: rtl/alarm_list.sv
// Ordered, compacting list of active alarm identifiers.
module alarm_list
    import alarm_list_pkg::*;
#(
    parameter int ID_W  = 11,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  set_req,
    input  logic [ID_W-1:0]       set_id,
    input  logic                  rst_req,
    input  logic [ID_W-1:0]       rst_id,
    input  logic                  ind_rst_req,
    output logic [DEPTH*ID_W-1:0] slots_o,
    output logic [CNT_W-1:0]      count_o,
    output logic [ID_W-1:0]       first_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    logic [ID_W-1:0]  slot_q   [DEPTH];
    logic [ID_W-1:0]  slot_d   [DEPTH];
    logic [ID_W-1:0]  nxt_val  [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    occ_e             occ_q;
    occ_e             occ_d;
    logic [DEPTH-1:0] valid;
    logic [DEPTH-1:0] rst_hit;
    logic [DEPTH-1:0] set_hit;
    logic             is_empty;
    logic             is_full;
    op_e              op;
    logic [IDX_W-1:0] del_pos;

    // Slot occupancy, flattened view and per-slot next-value lanes
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign valid[i]                  = (count_q > CNT_W'(i));
        assign slots_o[i*ID_W +: ID_W]   = slot_q[i];

        if (i == DEPTH - 1) begin : g_last
            assign nxt_val[i] = '0;
        end else begin : g_inner
            assign nxt_val[i] = slot_q[i+1];
        end

        alarm_slot_lane #(
            .ID_W  (ID_W),
            .IDX_W (IDX_W),
            .CNT_W (CNT_W),
            .INDEX (i)
        ) u_lane (
            .op       (op),
            .del_pos  (del_pos),
            .count    (count_q),
            .new_id   (set_id),
            .cur      (slot_q[i]),
            .nxt      (nxt_val[i]),
            .next_val (slot_d[i])
        );
    end

    alarm_match #(
        .ID_W  (ID_W),
        .DEPTH (DEPTH)
    ) u_rst_match (
        .slots (slots_o),
        .valid (valid),
        .key   (rst_id),
        .hit   (rst_hit)
    );

    alarm_match #(
        .ID_W  (ID_W),
        .DEPTH (DEPTH)
    ) u_set_match (
        .slots (slots_o),
        .valid (valid),
        .key   (set_id),
        .hit   (set_hit)
    );

    assign is_empty = (occ_q == ST_EMPTY);
    assign is_full  = (occ_q == ST_FULL);

    alarm_cmd_arb #(
        .DEPTH (DEPTH)
    ) u_arb (
        .ind_rst_req (ind_rst_req),
        .rst_req     (rst_req),
        .set_req     (set_req),
        .is_empty    (is_empty),
        .is_full     (is_full),
        .rst_hit     (rst_hit),
        .set_hit     (set_hit),
        .op          (op),
        .del_pos     (del_pos)
    );

    // Count update
    always_comb begin
        unique case (op)
            OP_ADD:         count_d = count_q + CNT_ONE;
            OP_DEL, OP_POP: count_d = count_q - CNT_ONE;
            default:        count_d = count_q;
        endcase
    end

    // Occupancy transitions
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            ST_EMPTY: begin
                if (op == OP_ADD) begin
                    occ_d = (DEPTH == 1) ? ST_FULL : ST_PART;
                end
            end
            ST_PART: begin
                if (op == OP_ADD && count_q == CNT_LAST) begin
                    occ_d = ST_FULL;
                end else if ((op == OP_DEL || op == OP_POP) && count_q == CNT_ONE) begin
                    occ_d = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (op == OP_DEL || op == OP_POP) begin
                    occ_d = (DEPTH == 1) ? ST_EMPTY : ST_PART;
                end
            end
            default: occ_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (clr) begin
            occ_q   <= ST_EMPTY;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            occ_q   <= occ_d;
            count_q <= count_d;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    // Outputs
    always_comb begin
        count_o = count_q;
        first_o = slot_q[0];
    end

endmodule

// File: rtl/alarm_list_chk.sv
// Port-level checker for alarm_list, attached by bind.
module alarm_list_chk #(
    parameter int ID_W  = 11,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  clr,
    input logic                  set_req,
    input logic [ID_W-1:0]       set_id,
    input logic                  rst_req,
    input logic [ID_W-1:0]       rst_id,
    input logic                  ind_rst_req,
    input logic [DEPTH*ID_W-1:0] slots_o,
    input logic [CNT_W-1:0]      count_o,
    input logic [ID_W-1:0]       first_o
);

    logic seen_clr = 1'b0;
    logic set_dup;
    logic rst_in;
    logic tail_ok;

    always_ff @(posedge clk) begin
        if (clr) begin
            seen_clr <= 1'b1;
        end
    end

    always_comb begin
        set_dup = 1'b0;
        rst_in  = 1'b0;
        tail_ok = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < count_o) begin
                if (slots_o[i*ID_W +: ID_W] == set_id) set_dup = 1'b1;
                if (slots_o[i*ID_W +: ID_W] == rst_id) rst_in  = 1'b1;
            end else if (slots_o[i*ID_W +: ID_W] != '0) begin
                tail_ok = 1'b0;
            end
        end
    end

    // R1
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!seen_clr)
        clr |=> (count_o == '0) && (slots_o == '0));

    // R2
    a_r2_set_grows: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        (set_req && !rst_req && !ind_rst_req && !set_dup && count_o < CNT_W'(DEPTH))
        |=> count_o == $past(count_o) + CNT_W'(1));

    // R3
    a_r3_dup_ignored: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        (set_req && !rst_req && !ind_rst_req && set_dup)
        |=> $stable(count_o) && $stable(slots_o));

    // R4
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        count_o <= CNT_W'(DEPTH));

    a_r4_full_set_ignored: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        (set_req && !rst_req && !ind_rst_req && count_o == CNT_W'(DEPTH))
        |=> $stable(count_o) && $stable(slots_o));

    // R5
    a_r5_delete_shrinks: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        (rst_req && !ind_rst_req && rst_in) |=> count_o == $past(count_o) - CNT_W'(1));

    // R6
    a_r6_absent_ignored: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        (rst_req && !ind_rst_req && !rst_in) |=> $stable(count_o) && $stable(slots_o));

    // R7, R11
    if (DEPTH > 1) begin : g_pop
        a_r7_pop_front: assert property (@(posedge clk) disable iff (clr || !seen_clr)
            (ind_rst_req && count_o != '0)
            |=> (count_o == $past(count_o) - CNT_W'(1))
                && (first_o == $past(slots_o[2*ID_W-1:ID_W])));
    end

    // R8
    a_r8_pop_empty: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        (ind_rst_req && count_o == '0) |=> (count_o == '0) && $stable(slots_o));

    // R10
    a_r10_tail_zero: assert property (@(posedge clk) disable iff (clr || !seen_clr)
        tail_ok);

endmodule

bind alarm_list alarm_list_chk #(.ID_W(ID_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/alarm_list_test.sv
`timescale 1ns/1ps
module alarm_list_test;

    localparam int ID_W  = 11;
    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                  clk = 1'b0;
    logic                  clr = 1'b1;
    logic                  set_req = 1'b0;
    logic [ID_W-1:0]       set_id = '0;
    logic                  rst_req = 1'b0;
    logic [ID_W-1:0]       rst_id = '0;
    logic                  ind_rst_req = 1'b0;
    logic [DEPTH*ID_W-1:0] slots_o;
    logic [CNT_W-1:0]      count_o;
    logic [ID_W-1:0]       first_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int m [DEPTH];
    int mc = 0;

    always #2.5 clk = ~clk;

    alarm_list #(.ID_W(ID_W), .DEPTH(DEPTH)) uut (
        .clk         (clk),
        .clr         (clr),
        .set_req     (set_req),
        .set_id      (set_id),
        .rst_req     (rst_req),
        .rst_id      (rst_id),
        .ind_rst_req (ind_rst_req),
        .slots_o     (slots_o),
        .count_o     (count_o),
        .first_o     (first_o)
    );

    function automatic int find(input int id);
        for (int k = 0; k < mc; k++) if (m[k] == id) return k;
        return -1;
    endfunction

    function automatic void remove_at(input int p);
        for (int k = p; k < DEPTH - 1; k++) m[k] = m[k+1];
        m[DEPTH-1] = 0;
        mc--;
    endfunction

    task automatic model(input bit c, input bit i, input bit r, input bit s,
                         input int rid, input int sid);
        if (c) begin
            for (int k = 0; k < DEPTH; k++) m[k] = 0;
            mc = 0;
        end else if (i) begin
            if (mc > 0) remove_at(0);
        end else if (r) begin
            if (find(rid) >= 0) remove_at(find(rid));
        end else if (s) begin
            if (mc < DEPTH && find(sid) < 0) begin
                m[mc] = sid;
                mc++;
            end
        end
    endtask

    task automatic check_all(input string tag);
        checks++;
        if (int'(count_o) != mc) begin
            errors++;
            $display("FAIL %s count: actual %0d expected %0d", tag, count_o, mc);
        end
        for (int k = 0; k < DEPTH; k++) begin
            checks++;
            if (int'(slots_o[k*ID_W +: ID_W]) != m[k]) begin
                errors++;
                $display("FAIL %s/R10 slot %0d: actual %0d expected %0d",
                         tag, k, slots_o[k*ID_W +: ID_W], m[k]);
            end
        end
        checks++;
        if (int'(first_o) != m[0]) begin
            errors++;
            $display("FAIL R11 first: actual %0d expected %0d", first_o, m[0]);
        end
    endtask

    // Called at a falling edge: drive, wait one clock, compare at the next falling edge
    task automatic step(input bit c, input bit i, input bit r, input bit s,
                        input int rid, input int sid, input string tag);
        clr = c; ind_rst_req = i; rst_req = r; set_req = s;
        rst_id = ID_W'(rid); set_id = ID_W'(sid);
        model(c, i, r, s, rid, sid);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        int unsigned x;
        int          rid;
        int          sid;
        bit          bi;
        bit          br;
        bit          bs;
        string       tag;

        for (int k = 0; k < DEPTH; k++) m[k] = 0;
        @(negedge clk);
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");

        // Activation-order sequence with a delete in the middle and an overflow
        step(0, 0, 0, 1, 0, 50, "R2");
        step(0, 0, 0, 1, 0, 25, "R2");
        step(0, 0, 0, 1, 0, 99, "R2");
        step(0, 0, 1, 0, 25, 0, "R5");
        step(0, 0, 0, 1, 0, 15, "R2");
        step(0, 0, 0, 1, 0, 70, "R2");
        step(0, 0, 0, 1, 0, 65, "R2");
        step(0, 0, 0, 1, 0, 38, "R2");
        step(0, 0, 0, 1, 0, 110, "R2");
        step(0, 0, 0, 1, 0, 151, "R2");
        step(0, 0, 0, 1, 0, 210, "R4");
        step(0, 0, 0, 1, 0, 2047, "R4");
        step(0, 0, 0, 1, 0, 99, "R3");
        step(0, 1, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 38, 0, "R5");
        step(0, 0, 1, 0, 151, 0, "R5");
        step(0, 0, 1, 0, 1234, 0, "R6");
        step(0, 0, 1, 0, 0, 0, "R12");
        step(0, 1, 1, 1, 15, 7, "R9");
        step(0, 0, 1, 1, 70, 8, "R9");
        step(1, 0, 0, 0, 0, 0, "R1");

        // Identifier 0 against zero-filled empty slots
        step(0, 0, 0, 1, 0, 5, "R2");
        step(0, 0, 1, 0, 0, 0, "R12");
        step(0, 0, 0, 1, 0, 0, "R12");
        step(0, 0, 0, 1, 0, 0, "R12");
        step(0, 0, 1, 0, 0, 0, "R12");
        step(0, 1, 0, 0, 0, 0, "R7");
        step(0, 1, 0, 0, 0, 0, "R8");
        step(0, 1, 0, 1, 0, 9, "R8");
        step(0, 1, 1, 0, 9, 0, "R9");

        // Pseudo-random sweep over a small identifier pool
        x = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            x ^= x << 13;
            x ^= x >> 17;
            x ^= x << 5;
            if (n % 500 == 499) begin
                step(1, 0, 0, 0, 0, 0, "R1");
                continue;
            end
            sid = (x[7:4] == 4'hF) ? 2047 : int'(x[3:0]);
            rid = (x[23:20] == 4'hF) ? 2047 : int'(x[19:16]);
            bi  = (x[10:8] == 3'd0);
            br  = (x[13:11] < 3'd3);
            bs  = (x[26:24] < 3'd5);
            if (int'(bi) + int'(br) + int'(bs) > 1) tag = "R9";
            else if (bi) tag = (mc == 0) ? "R8" : "R7";
            else if (br) tag = (find(rid) >= 0) ? "R5" : "R6";
            else if (bs) tag = (mc == DEPTH) ? "R4" : ((find(sid) >= 0) ? "R3" : "R2");
            else tag = "R10";
            step(0, bi, br, bs, rid, sid, tag);
        end

        finish_run();
    end

endmodule